// File: doc/BRIEF.md
# Offset Calibration and Power-Down Controller

This block sits after a two-channel decimation filter and before the serial output stage. It sequences three things: power-down, offset calibration and the return to normal operation. An active-low power-down request puts the block into a blanked state once the request has been low for a minimum number of clocks. In that state the data outputs are held at zero, the serial stage is told to drive its data line low, and the interface clock pins are turned into inputs.

When the request is released and calibration is armed by its active-low enable, the block opens a window of 2^CAL_LOG2 sample strobes. During the window it sums each channel's zero-input samples and stores the sum, divided by the window length, as that channel's offset. After the window one more strobe is swallowed while the output settles. From then on every sample has its channel's offset subtracted, and the result is clamped to the signed range of the data width. If the request is released with calibration disarmed, the block goes straight back to normal operation with both offsets cleared.

Top module: `ocal_ctrl`

## Requirements
- R1: After reset the data outputs are zero, and dout_valid, cal_busy, force_low and ifclk_in are all low.
- R2: In normal operation a strobe with offsets at zero gives dout equal to din on both channels, with dout_valid high for exactly the one cycle after the strobe edge.
- R3: Power-down is entered at the second consecutive clock edge that samples pd_n low, and force_low and ifclk_in are high from that edge onward. A pd_n low for only one edge has no effect on the outputs or on the data path.
- R4: While powered down, dout_valid stays low and both data outputs read zero, whatever strobes arrive.
- R5: Releasing pd_n while calibration is disarmed returns to normal operation at the next edge with both offsets cleared to zero.
- R6: Releasing pd_n while armed (cal_en_n low, sampled one clock earlier) starts a window of 2^CAL_LOG2 strobes. cal_busy is high from power-down entry until the edge that takes the last strobe of the window, and no dout_valid occurs before that edge.
- R7: Each channel's offset is the two's-complement sum of its window samples, arithmetically shifted right by CAL_LOG2 (rounded toward minus infinity).
- R8: After the window, force_low stays high and the next strobe is dropped. Every later strobe gives dout = din minus the stored offset.
- R9: A corrected value above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) is clamped to that limit.
- R10: If power-down qualifies at the same edge as the last strobe of a window, power-down wins. No offset is loaded, and cal_busy, force_low and ifclk_in stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low |
| cal_en_n | input | 1 | Calibration arm, active low |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| din_l | input | DATA_W | Left channel sample, two's complement |
| din_r | input | DATA_W | Right channel sample, two's complement |
| dout_l | output | DATA_W | Corrected left sample |
| dout_r | output | DATA_W | Corrected right sample |
| dout_valid | output | 1 | Corrected pair valid for one cycle |
| cal_busy | output | 1 | Calibration pending or in progress |
| force_low | output | 1 | Serial data line must be driven low |
| ifclk_in | output | 1 | Interface clock pins are inputs (powered down) |

## Verification
The sharpest overlap is the last strobe of a calibration window landing on the same edge at which a new power-down request qualifies. Both the offset load and the power-down entry want that edge. The bench sends 4095 window strobes, lowers pd_n one clock before the final strobe, and then checks that cal_busy, force_low and ifclk_in are all still high, which a settle state would not show. Releasing with calibration disarmed must then give uncorrected output. A second overlap is a strobe arriving in the cycle power-down qualifies during normal operation. The scoreboard treats any dout_valid it did not expect as a mismatch.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOWN   = 2'd1,
        ST_CAL    = 2'd2,
        ST_SETTLE = 2'd3
    } ocal_state_e;

endpackage

// File: rtl/ocal_seq.sv
module ocal_seq
    import ocal_pkg::*;
#(
    parameter int CAL_LOG2 = 12,
    parameter int PD_MIN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic cal_en_n,
    input  logic smp_stb,
    output logic acc_clr,
    output logic acc_en,
    output logic off_load,
    output logic off_clr,
    output logic pass_en,
    output logic out_valid,
    output logic cal_busy,
    output logic force_low,
    output logic ifclk_in
);

    localparam int LOW_W = $clog2(PD_MIN + 1);

    typedef struct packed {
        ocal_state_e         st;
        logic [LOW_W-1:0]    low_cnt;
        logic [CAL_LOG2-1:0] win_cnt;
        logic                arm;
        logic                vld;
    } seq_t;

    seq_t q, d;
    logic pd_enter;

    always_comb begin
        d        = q;
        acc_clr  = 1'b0;
        acc_en   = 1'b0;
        off_load = 1'b0;
        off_clr  = 1'b0;
        pass_en  = 1'b0;

        pd_enter = !pd_n && (q.low_cnt >= LOW_W'(PD_MIN - 1)) && (q.st != ST_DOWN);

        if (pd_n)
            d.low_cnt = '0;
        else if (q.low_cnt != LOW_W'(PD_MIN))
            d.low_cnt = q.low_cnt + 1'b1;

        d.arm = !cal_en_n;
        d.vld = 1'b0;

        case (q.st)
            ST_RUN: begin
                if (pd_enter) begin
                    d.st = ST_DOWN;
                end else if (smp_stb) begin
                    pass_en = 1'b1;
                    d.vld   = 1'b1;
                end
            end
            ST_DOWN: begin
                if (pd_n) begin
                    if (q.arm) begin
                        d.st      = ST_CAL;
                        d.win_cnt = '0;
                        acc_clr   = 1'b1;
                    end else begin
                        d.st    = ST_RUN;
                        off_clr = 1'b1;
                    end
                end
            end
            ST_CAL: begin
                if (pd_enter) begin
                    d.st = ST_DOWN;
                end else if (smp_stb) begin
                    if (q.win_cnt == '1) begin
                        off_load = 1'b1;
                        d.st     = ST_SETTLE;
                    end else begin
                        acc_en    = 1'b1;
                        d.win_cnt = q.win_cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (pd_enter)
                    d.st = ST_DOWN;
                else if (smp_stb)
                    d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_RUN;
            q.low_cnt <= '0;
            q.win_cnt <= '0;
            q.arm     <= 1'b0;
            q.vld     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.vld;
    assign force_low = (q.st != ST_RUN);
    assign ifclk_in  = (q.st == ST_DOWN);
    assign cal_busy  = (q.st == ST_CAL) || ((q.st == ST_DOWN) && q.arm);

    // R3
    blank_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_low) |-> !$past(pd_n));

    // R4
    valid_not_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !force_low);

    // R6
    busy_implies_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> force_low);

    // R6
    accum_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> cal_busy);

    // R8
    settle_still_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> force_low);

endmodule

// File: rtl/ocal_chan.sv
module ocal_chan #(
    parameter int DATA_W   = 20,
    parameter int CAL_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              acc_clr,
    input  logic              acc_en,
    input  logic              off_load,
    input  logic              off_clr,
    input  logic              pass_en,
    input  logic              force_low,
    output logic [DATA_W-1:0] dout
);

    localparam int ACC_W = DATA_W + CAL_LOG2;
    localparam logic [DATA_W-1:0] SAT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] off;
        logic [DATA_W-1:0] dout;
    } chan_t;

    chan_t q, d;
    logic [ACC_W-1:0]  din_ext;
    logic [ACC_W-1:0]  sum;
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] corr;

    always_comb begin
        d       = q;
        din_ext = {{CAL_LOG2{din[DATA_W-1]}}, din};
        sum     = q.acc + din_ext;

        diff = {din[DATA_W-1], din} - {q.off[DATA_W-1], q.off};
        if (diff[DATA_W] != diff[DATA_W-1])
            corr = diff[DATA_W] ? SAT_MIN : SAT_MAX;
        else
            corr = diff[DATA_W-1:0];

        if (acc_clr)
            d.acc = '0;
        else if (acc_en)
            d.acc = sum;

        if (off_clr)
            d.off = '0;
        else if (off_load)
            d.off = sum[CAL_LOG2 +: DATA_W];

        if (pass_en)
            d.dout = corr;
        else if (force_low)
            d.dout = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.acc  <= '0;
            q.off  <= '0;
            q.dout <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout = q.dout;

    // R4
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> (dout == '0));

    // R5
    cleared_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_clr |=> (q.off == '0));

endmodule

// File: rtl/ocal_ctrl.sv
module ocal_ctrl #(
    parameter int DATA_W   = 20,
    parameter int CAL_LOG2 = 12,
    parameter int PD_MIN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              cal_en_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] din_l,
    input  logic [DATA_W-1:0] din_r,
    output logic [DATA_W-1:0] dout_l,
    output logic [DATA_W-1:0] dout_r,
    output logic              dout_valid,
    output logic              cal_busy,
    output logic              force_low,
    output logic              ifclk_in
);

    localparam int NCH = 2;

    logic acc_clr, acc_en, off_load, off_clr, pass_en;
    logic [DATA_W-1:0] din_a  [NCH];
    logic [DATA_W-1:0] dout_a [NCH];

    assign din_a[0] = din_l;
    assign din_a[1] = din_r;
    assign dout_l   = dout_a[0];
    assign dout_r   = dout_a[1];

    ocal_seq #(
        .CAL_LOG2 (CAL_LOG2),
        .PD_MIN   (PD_MIN)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .cal_en_n  (cal_en_n),
        .smp_stb   (smp_stb),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .off_load  (off_load),
        .off_clr   (off_clr),
        .pass_en   (pass_en),
        .out_valid (dout_valid),
        .cal_busy  (cal_busy),
        .force_low (force_low),
        .ifclk_in  (ifclk_in)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ocal_chan #(
            .DATA_W   (DATA_W),
            .CAL_LOG2 (CAL_LOG2)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .din       (din_a[c]),
            .acc_clr   (acc_clr),
            .acc_en    (acc_en),
            .off_load  (off_load),
            .off_clr   (off_clr),
            .pass_en   (pass_en),
            .force_low (force_low),
            .dout      (dout_a[c])
        );
    end

endmodule

// File: tb/test_ocal_ctrl.sv
module test_ocal_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 20;
    localparam int CL2 = 12;
    localparam int WIN = 1 << CL2;

    logic clk = 1'b0;
    logic rst_n, pd_n, cal_en_n, smp_stb;
    logic [DW-1:0] din_l, din_r;
    logic [DW-1:0] dout_l, dout_r;
    logic dout_valid, cal_busy, force_low, ifclk_in;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_l_q[$];
    int exp_r_q[$];
    string tag_q[$];
    longint off_l = 0, off_r = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocal_ctrl #(.DATA_W(DW), .CAL_LOG2(CL2), .PD_MIN(2)) i_ocal_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cal_en_n(cal_en_n),
        .smp_stb(smp_stb), .din_l(din_l), .din_r(din_r),
        .dout_l(dout_l), .dout_r(dout_r), .dout_valid(dout_valid),
        .cal_busy(cal_busy), .force_low(force_low), .ifclk_in(ifclk_in)
    );

    function automatic int sat20(longint v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return int'(v);
    endfunction

    function automatic int sx(logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(int l, int r, bit expect_out, string tag);
        @(negedge clk);
        smp_stb = 1'b1;
        din_l   = DW'(l);
        din_r   = DW'(r);
        if (expect_out) begin
            exp_l_q.push_back(sat20(longint'(l) - off_l));
            exp_r_q.push_back(sat20(longint'(r) - off_r));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected pairs as the design presents them
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (exp_l_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R4/R6: unexpected valid, actual %0d/%0d expected none",
                         sx(dout_l), sx(dout_r));
            end else begin
                string t;
                t = tag_q.pop_front();
                chk({t, " left"},  sx(dout_l), exp_l_q.pop_front());
                chk({t, " right"}, sx(dout_r), exp_r_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        longint sum_l, sum_r;
        rst_n = 1'b0; pd_n = 1'b1; cal_en_n = 1'b1; smp_stb = 1'b0;
        din_l = '0; din_r = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dout_l", sx(dout_l), 0);
        chk("R1 dout_r", sx(dout_r), 0);
        chk("R1 valid", int'(dout_valid), 0);
        chk("R1 busy", int'(cal_busy), 0);
        chk("R1 force_low", int'(force_low), 0);
        chk("R1 ifclk_in", int'(ifclk_in), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 pass-through with zero offsets
        send(100, -100, 1'b1, "R2");
        send(524287, -524288, 1'b1, "R2");
        send(0, 5, 1'b1, "R2");

        // R3 one-clock glitch ignored
        @(negedge clk); pd_n = 1'b0;
        @(negedge clk); pd_n = 1'b1;
        chk("R3 glitch force_low", int'(force_low), 0);
        @(negedge clk);
        chk("R3 glitch ifclk_in", int'(ifclk_in), 0);
        send(-7, 9, 1'b1, "R3");

        // R3/R4/R5 power-down with calibration disarmed
        @(negedge clk); pd_n = 1'b0;
        @(negedge clk);
        chk("R3 first edge", int'(force_low), 0);
        @(negedge clk);
        chk("R3 force_low", int'(force_low), 1);
        chk("R3 ifclk_in", int'(ifclk_in), 1);
        chk("R3 busy disarmed", int'(cal_busy), 0);
        send(1234, 4321, 1'b0, "R4");
        chk("R4 dout_l", sx(dout_l), 0);
        chk("R4 dout_r", sx(dout_r), 0);
        pd_n = 1'b1;
        @(negedge clk);
        chk("R5 force_low", int'(force_low), 0);
        send(-300, 300, 1'b1, "R5");

        // R6/R7/R8 calibration
        cal_en_n = 1'b0;
        repeat (2) @(negedge clk);
        pd_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 busy", int'(cal_busy), 1);
        chk("R6 force_low", int'(force_low), 1);
        repeat (2) @(negedge clk);
        pd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 busy in window", int'(cal_busy), 1);
        chk("R6 ifclk_in", int'(ifclk_in), 0);
        sum_l = 0; sum_r = 0;
        for (int i = 0; i < WIN; i++) begin
            int l, r;
            l = 36 + 3 * (i % 2);
            r = -249 - (i % 2);
            sum_l += l;
            sum_r += r;
            send(l, r, 1'b0, "R6");
            if (i == WIN/2) chk("R6 busy mid", int'(cal_busy), 1);
        end
        off_l = sum_l >>> CL2;
        off_r = sum_r >>> CL2;
        chk("R7 model left", int'(off_l), 37);
        chk("R7 model right", int'(off_r), -250);
        chk("R8 busy after window", int'(cal_busy), 0);
        chk("R8 force_low settle", int'(force_low), 1);
        send(55, 55, 1'b0, "R8");
        chk("R8 force_low run", int'(force_low), 0);
        send(1000, 1000, 1'b1, "R7 R8");
        send(0, 0, 1'b1, "R7");
        send(-524288, 524287, 1'b1, "R9");
        send(524287, -524288, 1'b1, "R9");

        // R10 power-down qualifies on the last strobe of the window
        pd_n = 1'b0;
        repeat (3) @(negedge clk);
        pd_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < WIN - 1; i++) send(9, -9, 1'b0, "R10");
        @(negedge clk); pd_n = 1'b0;
        @(negedge clk); smp_stb = 1'b1; din_l = DW'(9); din_r = DW'(-9);
        @(negedge clk); smp_stb = 1'b0;
        chk("R10 busy", int'(cal_busy), 1);
        chk("R10 force_low", int'(force_low), 1);
        chk("R10 ifclk_in", int'(ifclk_in), 1);
        repeat (2) @(negedge clk);
        chk("R10 still down", int'(ifclk_in), 1);
        cal_en_n = 1'b1;
        repeat (2) @(negedge clk);
        pd_n = 1'b1;
        off_l = 0; off_r = 0;
        repeat (2) @(negedge clk);
        send(77, -77, 1'b1, "R10 R5");
        repeat (4) @(negedge clk);

        chk("queue drained", exp_l_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule